// File: doc/BRIEF.md
# Dual-Format Six-Channel Serial Audio Deserializer

This block turns one serial audio data line into six parallel sample words per frame. It runs in the bit-clock domain. The bit clock is the block clock, and one frame is 256 bit clocks, which is one sample period. A frame-clock input marks where each frame begins. The way it does so depends on the format chosen by `fmt_tdm`.

In the split-frame format (`fmt_tdm` = 0), the frame clock is high for the first half of the frame and low for the second half. Each half carries three 24-bit slots. In the TDM format (`fmt_tdm` = 1), a frame-clock pulse one bit clock long comes just before the frame. Six 32-bit slots then follow back to back.

In both formats each sample sits at the top of its slot. A length code keeps only the selected number of leading bits. When the last bit of a frame has been taken in, all six outputs are loaded together and a one-cycle valid strobe is raised. If a new frame starts before the current one is complete, the partial frame is dropped and a one-cycle error flag is raised.

Top module: `aud_deser_top`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first frame completes, all `ch_data` words are zero and `frame_valid` and `frame_err` are low.
- R2: When `fmt_tdm` = 0, a frame starts on the rising edge of `clk` where `fr_clk` is first sampled high after being low. That same edge captures the MSB of channel 0. Channels 0, 1 and 2 then occupy consecutive 24-bit slots, MSB first.
- R3: When `fmt_tdm` = 0, the edge where `fr_clk` is first sampled low after being high sets the frame bit index to 128. Channels 3, 4 and 5 occupy consecutive 24-bit slots from that edge on. Bits 72..127 and 200..255 of the frame carry no sample.
- R4: When `fmt_tdm` = 1, a frame starts on the edge after the one where `fr_clk` is first sampled high. That edge captures the MSB of channel 0. Channels 0 to 5 occupy consecutive 32-bit slots, MSB first. Bits 192..255 carry no sample.
- R5: The length code `len_code`, sampled at frame start, selects the kept length: 0 = 16, 1 = 18, 2 = 20, 3 = 24, 4 = 32 bits, and 5..7 = 24 bits. Each output word holds the kept bits at bits [31:32-len]. All lower bits are zero, whatever the line carried in the rest of the slot.
- R6: When `fmt_tdm` = 0, code 4 keeps 24 bits, the full slot.
- R7: `frame_valid` is high for exactly one cycle, the cycle after the edge that takes frame bit 255. All six words change in that cycle and are held unchanged at every other time.
- R8: A frame start that comes while a frame is still being received raises `frame_err` for one cycle. The partial frame is discarded: no `frame_valid` and no change to `ch_data`. The new frame is then captured normally.
- R9: When no frame is being received, line activity other than a frame start has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| fmt_tdm | input | 1 | 0 = split-frame 24-bit slots, 1 = TDM 32-bit slots |
| len_code | input | 3 | Valid-length code (see R5) |
| fr_clk | input | 1 | Frame clock / frame pulse |
| sdata | input | 1 | Serial data line |
| ch_data | output | 6x32 | Six sample words, MSB-aligned, channel 0 in the low element |
| frame_valid | output | 1 | One-cycle strobe when new words are loaded |
| frame_err | output | 1 | One-cycle flag for a discarded partial frame |

## Verification
The bench builds the block with its default parameters. These are a 256-bit frame, 24-bit and 32-bit slots and six channels, so every slot boundary, each dead zone at the end of a half or a frame, and the 32-bit length in TDM are all exercised. Frames are cut short after 150 bits in the split format and after 100 bits in TDM. This shows that a discarded frame leaves the held words untouched and that the next frame is captured cleanly. Random fill in the unused slot bits and dead zones shows that only the kept bits reach the outputs.

// File: rtl/aud_deser_pkg.sv
package aud_deser_pkg;
    localparam int NUM_CH     = 6;
    localparam int SAMPLE_W   = 32;
    localparam int FRAME_BITS = 256;
    localparam int SPLIT_SLOT = 24;
    localparam int TDM_SLOT   = 32;

    typedef enum logic [2:0] {
        LEN_16 = 3'd0,
        LEN_18 = 3'd1,
        LEN_20 = 3'd2,
        LEN_24 = 3'd3,
        LEN_32 = 3'd4
    } len_code_e;
endpackage

// File: rtl/aud_len_decode.sv
module aud_len_decode #(
    parameter int SPLIT_SLOT = 24,
    parameter int TDM_SLOT   = 32,
    localparam int NB_W      = $clog2(TDM_SLOT) + 1
) (
    input  logic            tdm,
    input  logic [2:0]      code,
    output logic [NB_W-1:0] nbits
);
    import aud_deser_pkg::*;

    always_comb begin
        case (len_code_e'(code))
            LEN_16:  nbits = NB_W'(16);
            LEN_18:  nbits = NB_W'(18);
            LEN_20:  nbits = NB_W'(20);
            LEN_32:  nbits = tdm ? NB_W'(TDM_SLOT) : NB_W'(SPLIT_SLOT);
            default: nbits = NB_W'(24);
        endcase
    end
endmodule

// File: rtl/aud_slot_map.sv
module aud_slot_map #(
    parameter int NUM_CH     = 6,
    parameter int FRAME_BITS = 256,
    parameter int SPLIT_SLOT = 24,
    parameter int TDM_SLOT   = 32,
    localparam int IDX_W     = $clog2(FRAME_BITS),
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int POS_W     = $clog2(TDM_SLOT),
    localparam int HALF      = FRAME_BITS / 2,
    localparam int PER_HALF  = NUM_CH / 2
) (
    input  logic             tdm,
    input  logic [IDX_W-1:0] bit_idx,
    output logic             hit,
    output logic [CH_W-1:0]  ch,
    output logic [POS_W-1:0] pos
);
    int bi;
    int hb;
    int base;

    always_comb begin
        hit  = 1'b0;
        ch   = '0;
        pos  = '0;
        bi   = int'(bit_idx);
        hb   = (bi >= HALF) ? bi - HALF : bi;
        base = (bi >= HALF) ? PER_HALF : 0;
        if (tdm) begin
            for (int s = 0; s < NUM_CH; s++) begin
                if (bi >= s * TDM_SLOT && bi < (s + 1) * TDM_SLOT) begin
                    hit = 1'b1;
                    ch  = CH_W'(s);
                    pos = POS_W'(bi - s * TDM_SLOT);
                end
            end
        end else begin
            for (int s = 0; s < PER_HALF; s++) begin
                if (hb >= s * SPLIT_SLOT && hb < (s + 1) * SPLIT_SLOT) begin
                    hit = 1'b1;
                    ch  = CH_W'(s + base);
                    pos = POS_W'(hb - s * SPLIT_SLOT);
                end
            end
        end
    end
endmodule

// File: rtl/aud_deser_top.sv
module aud_deser_top #(
    parameter int NUM_CH     = aud_deser_pkg::NUM_CH,
    parameter int SAMPLE_W   = aud_deser_pkg::SAMPLE_W,
    parameter int FRAME_BITS = aud_deser_pkg::FRAME_BITS,
    parameter int SPLIT_SLOT = aud_deser_pkg::SPLIT_SLOT,
    parameter int TDM_SLOT   = aud_deser_pkg::TDM_SLOT
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               fmt_tdm,
    input  logic [2:0]                         len_code,
    input  logic                               fr_clk,
    input  logic                               sdata,
    output logic [NUM_CH-1:0][SAMPLE_W-1:0]    ch_data,
    output logic                               frame_valid,
    output logic                               frame_err
);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int POS_W = $clog2(TDM_SLOT);
    localparam int NB_W  = POS_W + 1;
    localparam logic [IDX_W-1:0] HALF_IDX = IDX_W'(FRAME_BITS / 2);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic                            fr_prev;
        logic                            pend;
        logic                            active;
        logic [IDX_W-1:0]                cnt;
        logic [NB_W-1:0]                 nbits;
        logic [NUM_CH-1:0][SAMPLE_W-1:0] shadow;
        logic [NUM_CH-1:0][SAMPLE_W-1:0] words;
        logic                            valid;
        logic                            err;
    } state_t;

    state_t st_q, st_d;

    logic             start_now, take_now, rise_now, fall_now;
    logic [IDX_W-1:0] idx_now;
    logic [NB_W-1:0]  len_now, nb_now;
    logic             map_hit;
    logic [CH_W-1:0]  map_ch;
    logic [POS_W-1:0] map_pos;

    aud_len_decode #(.SPLIT_SLOT(SPLIT_SLOT), .TDM_SLOT(TDM_SLOT)) u_len (
        .tdm   (fmt_tdm),
        .code  (len_code),
        .nbits (len_now)
    );

    aud_slot_map #(
        .NUM_CH(NUM_CH), .FRAME_BITS(FRAME_BITS),
        .SPLIT_SLOT(SPLIT_SLOT), .TDM_SLOT(TDM_SLOT)
    ) u_map (
        .tdm     (fmt_tdm),
        .bit_idx (idx_now),
        .hit     (map_hit),
        .ch      (map_ch),
        .pos     (map_pos)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.err   = 1'b0;
        rise_now   = fr_clk & ~st_q.fr_prev;
        fall_now   = ~fr_clk & st_q.fr_prev;
        st_d.fr_prev = fr_clk;
        st_d.pend  = fmt_tdm & rise_now;
        start_now  = fmt_tdm ? st_q.pend : rise_now;
        take_now   = 1'b0;
        idx_now    = st_q.cnt;
        nb_now     = st_q.nbits;

        if (start_now) begin
            st_d.err    = st_q.active;
            st_d.active = 1'b1;
            st_d.shadow = '0;
            st_d.nbits  = len_now;
            nb_now      = len_now;
            idx_now     = '0;
            take_now    = 1'b1;
        end else if (!fmt_tdm && fall_now && st_q.active) begin
            idx_now  = HALF_IDX;
            take_now = 1'b1;
        end else if (st_q.active) begin
            take_now = 1'b1;
        end

        if (take_now) begin
            st_d.cnt = idx_now + 1'b1;
            if (map_hit && ({1'b0, map_pos} < nb_now)) begin
                st_d.shadow[map_ch][SAMPLE_W-1-int'(map_pos)] = sdata;
            end
            if (idx_now == LAST_IDX) begin
                st_d.words  = st_d.shadow;
                st_d.valid  = 1'b1;
                st_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ch_data     = st_q.words;
    assign frame_valid = st_q.valid;
    assign frame_err   = st_q.err;

    // Low bits beyond the latched length must be clear in every word.
    logic [SAMPLE_W-1:0] keep_mask;
    logic                tails_clear;
    always_comb begin
        keep_mask   = ~({SAMPLE_W{1'b1}} >> st_q.nbits);
        tails_clear = 1'b1;
        for (int c = 0; c < NUM_CH; c++) begin
            if ((ch_data[c] & ~keep_mask) != '0) tails_clear = 1'b0;
        end
    end

    assert_tail_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> tails_clear);

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    assert_words_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> $stable(ch_data));

    assert_err_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !frame_valid);

    assert_err_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> (st_q.active && st_q.cnt == IDX_W'(1)));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !st_q.pend && !(fr_clk && !st_q.fr_prev)) |=> !frame_valid && !frame_err);
endmodule

// File: tb/aud_deser_top_bench.sv
module aud_deser_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;
    localparam int WATCHDOG = 150000;

    typedef logic [NCH-1:0][31:0] frame_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fmt_tdm = 1'b0;
    logic [2:0] len_code = 3'd3;
    logic fr_clk = 1'b0;
    logic sdata = 1'b0;
    frame_t ch_data;
    logic frame_valid, frame_err;

    int checks = 0;
    int fails = 0;
    int exp_errs = 0;
    int seen_errs = 0;
    int cycles = 0;
    string cur_req = "R2";
    frame_t exp_q[$];
    frame_t last_words = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    aud_deser_top u_aud_deser_top (
        .clk(clk), .rst_n(rst_n), .fmt_tdm(fmt_tdm), .len_code(len_code),
        .fr_clk(fr_clk), .sdata(sdata), .ch_data(ch_data),
        .frame_valid(frame_valid), .frame_err(frame_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    function automatic int kept_len(input bit tdm, input int code);
        case (code)
            0: return 16;
            1: return 18;
            2: return 20;
            4: return tdm ? 32 : 24;
            default: return 24;
        endcase
    endfunction

    task automatic drive(input logic l, input logic d);
        @(negedge clk);
        fr_clk = l;
        sdata  = d;
    endtask

    // Driver: sends frames and pushes the expected words (R2..R6).
    task automatic run_frames(input bit tdm, input int code, input int nfr, input bit pre);
        fmt_tdm  = tdm;
        len_code = 3'(code);
        if (tdm && pre) drive(1'b1, 1'($urandom));
        for (int f = 0; f < nfr; f++) begin
            frame_t s, e;
            logic [31:0] mask;
            mask = ~(32'hFFFF_FFFF >> kept_len(tdm, code));
            for (int c = 0; c < NCH; c++) begin
                s[c] = $urandom;
                e[c] = s[c] & mask;
            end
            exp_q.push_back(e);
            for (int i = 0; i < 256; i++) begin
                logic d, l;
                d = 1'($urandom);
                if (tdm) begin
                    if (i / 32 < NCH) d = s[i / 32][31 - (i % 32)];
                    l = (i == 255) && (f < nfr - 1);
                end else begin
                    int h;
                    h = i % 128;
                    if (h / 24 < 3) d = s[h / 24 + ((i >= 128) ? 3 : 0)][31 - (h % 24)];
                    l = (i < 128);
                end
                drive(l, d);
            end
        end
        for (int k = 0; k < 4; k++) drive(1'b0, 1'($urandom));
    endtask

    // Partial frame cut short by a new start, then one full frame (R8).
    task automatic run_cut(input bit tdm, input int code, input int nbits);
        fmt_tdm  = tdm;
        len_code = 3'(code);
        if (tdm) drive(1'b1, 1'b0);
        for (int i = 0; i < nbits; i++) begin
            drive(tdm ? (i == nbits - 1) : (i < 128), 1'($urandom));
        end
        exp_errs++;
        run_frames(tdm, code, 1, 1'b0);
    endtask

    // Monitor: pops expected frames as the design reports them.
    always @(negedge clk) begin
        if (rst_n && frame_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected frame_valid", 32'd1, 32'd0);
            end else begin
                frame_t e;
                e = exp_q.pop_front();
                for (int c = 0; c < NCH; c++) begin
                    check(ch_data[c] === e[c], cur_req, $sformatf("channel %0d word", c),
                          ch_data[c], e[c]);
                end
                last_words = e;
            end
        end
        if (rst_n && frame_err) begin
            seen_errs++;
            for (int c = 0; c < NCH; c++) begin
                check(ch_data[c] === last_words[c], "R8", "words kept on error",
                      ch_data[c], last_words[c]);
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                check(1'b0, "watchdog", "run did not finish", 32'(cycles), 32'(WATCHDOG));
                finish_run();
            end
        end
    end

    initial begin
        for (int k = 0; k < 5; k++) drive(1'b0, 1'b1);
        // R1: reset state
        check(ch_data === '0, "R1", "words during reset", ch_data[0], 32'd0);
        check(frame_valid === 1'b0, "R1", "valid during reset", 32'(frame_valid), 32'd0);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) drive(1'b0, 1'($urandom));
        check(ch_data === '0, "R1", "words after reset", ch_data[0], 32'd0);
        check(frame_err === 1'b0, "R1", "err after reset", 32'(frame_err), 32'd0);

        cur_req = "R2_R3";  run_frames(1'b0, 3, 3, 1'b1);
        cur_req = "R5";     run_frames(1'b0, 0, 2, 1'b1);
        cur_req = "R5";     run_frames(1'b0, 1, 1, 1'b1);
        cur_req = "R6";     run_frames(1'b0, 4, 2, 1'b1);
        cur_req = "R4";     run_frames(1'b1, 4, 3, 1'b1);
        cur_req = "R5";     run_frames(1'b1, 2, 2, 1'b1);
        cur_req = "R5";     run_frames(1'b1, 1, 1, 1'b1);
        cur_req = "R8";     run_cut(1'b0, 3, 150);
        cur_req = "R8";     run_cut(1'b1, 4, 100);

        // R9: idle line toggling data with no frame start changes nothing
        for (int k = 0; k < 40; k++) begin
            drive(1'b0, 1'($urandom));
            check(frame_valid === 1'b0, "R9", "valid while idle", 32'(frame_valid), 32'd0);
        end
        for (int c = 0; c < NCH; c++) begin
            check(ch_data[c] === last_words[c], "R9", "words held while idle",
                  ch_data[c], last_words[c]);
        end
        check(exp_q.size() == 0, "R7", "frames left unreported", 32'(exp_q.size()), 32'd0);
        check(seen_errs == exp_errs, "R8", "error pulses", 32'(seen_errs), 32'(exp_errs));
        finish_run();
    end
endmodule